// File: doc/BRIEF.md
# Dual-Clock FIFO with Selectable Fall-Through Read

This block moves data words from a write clock domain to an unrelated read clock domain through an internal memory of `DEPTH` words. Write and read pointers cross the domain boundary as Gray-coded values through two-flop synchronizers. Each pointer carries one wrap bit beyond the address, which lets the block tell a full memory from an empty one.

The read behaviour is chosen during master reset. In standard mode, every word must be requested. `rd_valid` means that at least one word is waiting in memory. A read loads that word into the output register one read-clock edge later. In fall-through mode, the head word moves into the output register without any request. `rd_valid` then means that `rd_data` holds a word. A read consumes the word shown. In this mode the output register acts as one extra storage slot, so the block holds `DEPTH + 1` words.

Both sides follow a valid/ready scheme. A write transfers when `wr_en` and `wr_ready` are both high at a rising `wclk` edge. When `wr_ready` is low, the writer is back-pressured and any `wr_en` is dropped. A read transfers when `rd_en` and `rd_valid` are both high at a rising `rclk` edge. When `rd_valid` is low, `rd_en` is ignored. A flag that is released by activity in the other domain lags that activity by two cycles of its own clock.

Top module: `xfifo_dc`

## Requirements
- R1: In standard mode, starting from reset with no reads, exactly `DEPTH` writes are accepted. `wr_ready` is then low.
- R2: In fall-through mode, starting from reset with no reads, `DEPTH + 1` writes are accepted, provided the first word has had time to reach the output register. `wr_ready` is then low.
- R3: A write while `wr_ready` is low is dropped. The stored words and their order are unchanged, and the dropped value is never read out.
- R4: In standard mode, a read loads the head word onto `rd_data` at that `rclk` edge. Without a read, `rd_data` keeps its previous value.
- R5: In standard mode, `rd_en` while `rd_valid` is low has no effect. `rd_data` keeps its value, and the next word written is the next word read.
- R6: In fall-through mode, the first word written into an empty FIFO appears on `rd_data` on the third rising `rclk` edge after the write, with no `rd_en`. `rd_valid` rises on that same edge.
- R7: In fall-through mode, `rd_valid` stays high with `rd_data` stable after the last stored word has moved to the output. `rd_valid` falls only on an `rclk` edge with `rd_en` high, and `rd_data` then keeps showing that last word.
- R8: Release latency across domains is two cycles. In standard mode, `rd_valid` rises on the second `rclk` edge after a write into an empty FIFO. `wr_ready` rises on the second `wclk` edge after a read from a full FIFO.
- R9: Words leave in the order they were accepted, across pointer wrap-around, in both modes.
- R10: `fwft_sel` is sampled while `mrst_n` is low and at the first `rclk` edge after release (0 = standard, 1 = fall-through). Later changes have no effect.
- R11: Directly after reset, `wr_ready` is 1, `rd_valid` is 0 and `rd_data` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write clock |
| rclk | input | 1 | Read clock, unrelated to `wclk` |
| mrst_n | input | 1 | Master reset, active low, asynchronous assertion |
| fwft_sel | input | 1 | Read mode select sampled in reset: 0 standard, 1 fall-through |
| wr_en | input | 1 | Write request (valid) |
| wr_data | input | DW | Write data word |
| wr_ready | output | 1 | Space available; low means full |
| rd_en | input | 1 | Read request (ready) |
| rd_data | output | DW | Output register |
| rd_valid | output | 1 | Standard: word waiting in memory. Fall-through: `rd_data` holds a word |
| | | | |

## Verification
Most internal faults show up at the ports quickly. A wrong pointer increment or Gray conversion shows as a repeated, skipped or reordered word within one pass through memory. A wrong full or empty comparison shows as a capacity other than `DEPTH` or `DEPTH + 1` words at the first fill. A missing synchronizer stage shows as a flag edge one cycle early. A wrong output-register valid rule shows within a few read cycles, either as `rd_valid` dropping without a read or as `rd_data` changing while it is held.

// File: rtl/xfifo_pkg.sv
package xfifo_pkg;

  typedef enum logic {
    MODE_STD  = 1'b0,
    MODE_FWFT = 1'b1
  } rd_mode_e;

  localparam int PTR_MAX = 32;

  function automatic logic [PTR_MAX-1:0] bin_to_gray(input logic [PTR_MAX-1:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [PTR_MAX-1:0] gray_to_bin(input logic [PTR_MAX-1:0] g);
    logic [PTR_MAX-1:0] b;
    b[PTR_MAX-1] = g[PTR_MAX-1];
    for (int i = PTR_MAX - 2; i >= 0; i--) begin
      b[i] = b[i+1] ^ g[i];
    end
    return b;
  endfunction

endpackage

// File: rtl/xfifo_sync.sv
module xfifo_sync #(
  parameter int W      = 5,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] stg [STAGES];

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stg[0] <= '0;
          else        stg[0] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stg[s] <= '0;
          else        stg[s] <= stg[s-1];
        end
      end
    end
  endgenerate

  assign q = stg[STAGES-1];

endmodule

// File: rtl/xfifo_mem.sv
module xfifo_mem #(
  parameter int DW = 16,
  parameter int AW = 4
) (
  input  logic          wclk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);

  localparam int WORDS = 1 << AW;

  logic [DW-1:0] ram [WORDS];

  always_ff @(posedge wclk) begin
    if (we) ram[waddr] <= wdata;
  end

  assign rdata = ram[raddr];

endmodule

// File: rtl/xfifo_wctl.sv
module xfifo_wctl
  import xfifo_pkg::*;
#(
  parameter int AW = 4
) (
  input  logic          wclk,
  input  logic          mrst_n,
  input  logic          wr_en,
  input  logic [AW:0]   rgray_s,
  output logic          wr_ready,
  output logic          we,
  output logic [AW-1:0] waddr,
  output logic [AW:0]   wgray
);

  localparam logic [AW:0] DEPTH_L = (AW+1)'(1 << AW);

  logic [AW:0]         wbin;
  logic [AW:0]         wbin_nx;
  logic [PTR_MAX-1:0]  rbin_wide;
  logic [AW:0]         rbin_s;
  logic [AW:0]         occ;
  logic                full;

  // full: top two Gray bits inverted, rest equal
  assign full     = (wgray == {~rgray_s[AW:AW-1], rgray_s[AW-2:0]});
  assign wr_ready = ~full;
  assign we       = wr_en & ~full;
  assign waddr    = wbin[AW-1:0];
  assign wbin_nx  = wbin + 1'b1;

  always_ff @(posedge wclk or negedge mrst_n) begin
    if (!mrst_n) begin
      wbin  <= '0;
      wgray <= '0;
    end else if (we) begin
      wbin  <= wbin_nx;
      wgray <= bin_to_gray(PTR_MAX'(wbin_nx))[AW:0];
    end
  end

  assign rbin_wide = gray_to_bin(PTR_MAX'(rgray_s));
  assign rbin_s    = rbin_wide[AW:0];
  assign occ       = wbin - rbin_s;

  // R3
  wr_drop_full_chk: assert property (@(posedge wclk) disable iff (!mrst_n)
    (wr_en && !wr_ready) |=> $stable(wbin));

  // R1
  occ_bound_chk: assert property (@(posedge wclk) disable iff (!mrst_n)
    occ <= DEPTH_L);

  // R1
  full_means_depth_chk: assert property (@(posedge wclk) disable iff (!mrst_n)
    !wr_ready |-> (occ == DEPTH_L));

endmodule

// File: rtl/xfifo_rctl.sv
module xfifo_rctl
  import xfifo_pkg::*;
#(
  parameter int DW = 16,
  parameter int AW = 4
) (
  input  logic          rclk,
  input  logic          mrst_n,
  input  logic          fwft_sel,
  input  logic          rd_en,
  input  logic [AW:0]   wgray_s,
  input  logic [DW-1:0] mem_rdata,
  output logic [AW-1:0] raddr,
  output logic [AW:0]   rgray,
  output logic [DW-1:0] rd_data,
  output logic          rd_valid
);

  rd_mode_e      mode_r;
  logic          arm;
  logic [AW:0]   rbin;
  logic [AW:0]   rbin_nx;
  logic          mem_ne;
  logic          out_v;
  logic          pop;

  // arm is high through reset and until the first edge after release
  always_ff @(posedge rclk or negedge mrst_n) begin
    if (!mrst_n) arm <= 1'b1;
    else         arm <= 1'b0;
  end

  always_ff @(posedge rclk) begin
    if (arm) mode_r <= rd_mode_e'(fwft_sel);
  end

  assign mem_ne  = (rgray != wgray_s);
  assign raddr   = rbin[AW-1:0];
  assign rbin_nx = rbin + 1'b1;

  always_comb begin
    if (mode_r == MODE_FWFT) pop = mem_ne & (~out_v | rd_en);
    else                     pop = mem_ne & rd_en;
  end

  always_ff @(posedge rclk or negedge mrst_n) begin
    if (!mrst_n) begin
      rbin    <= '0;
      rgray   <= '0;
      rd_data <= '0;
    end else if (pop) begin
      rbin    <= rbin_nx;
      rgray   <= bin_to_gray(PTR_MAX'(rbin_nx))[AW:0];
      rd_data <= mem_rdata;
    end
  end

  always_ff @(posedge rclk or negedge mrst_n) begin
    if (!mrst_n) begin
      out_v <= 1'b0;
    end else if (mode_r == MODE_FWFT) begin
      if (pop)        out_v <= 1'b1;
      else if (rd_en) out_v <= 1'b0;
    end else begin
      out_v <= 1'b0;
    end
  end

  assign rd_valid = (mode_r == MODE_FWFT) ? out_v : mem_ne;

  // R4
  std_hold_chk: assert property (@(posedge rclk) disable iff (!mrst_n)
    (mode_r == MODE_STD && !(rd_en && rd_valid)) |=> $stable(rd_data));

  // R5
  empty_noadv_chk: assert property (@(posedge rclk) disable iff (!mrst_n)
    (!mem_ne) |=> $stable(rbin));

  // R7
  fwft_keep_chk: assert property (@(posedge rclk) disable iff (!mrst_n)
    (mode_r == MODE_FWFT && rd_valid && !rd_en) |=> (rd_valid && $stable(rd_data)));

  // R7
  fwft_last_chk: assert property (@(posedge rclk) disable iff (!mrst_n)
    (mode_r == MODE_FWFT && rd_valid && rd_en && !mem_ne) |=> (!rd_valid && $stable(rd_data)));

  // R10
  mode_hold_chk: assert property (@(posedge rclk) disable iff (!mrst_n)
    !arm |=> $stable(mode_r));

endmodule

// File: rtl/xfifo_dc.sv
module xfifo_dc #(
  parameter int DW    = 16,
  parameter int DEPTH = 16
) (
  input  logic          wclk,
  input  logic          rclk,
  input  logic          mrst_n,
  input  logic          fwft_sel,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  output logic          wr_ready,
  input  logic          rd_en,
  output logic [DW-1:0] rd_data,
  output logic          rd_valid
);

  // DEPTH must be a power of two, at least 4
  localparam int AW     = $clog2(DEPTH);
  localparam int STAGES = 2;

  logic          we;
  logic [AW-1:0] waddr;
  logic [AW-1:0] raddr;
  logic [DW-1:0] mem_rdata;
  logic [AW:0]   wgray;
  logic [AW:0]   rgray;
  logic [AW:0]   wgray_s;
  logic [AW:0]   rgray_s;

  xfifo_wctl #(.AW(AW)) u_wctl (
    .wclk     (wclk),
    .mrst_n   (mrst_n),
    .wr_en    (wr_en),
    .rgray_s  (rgray_s),
    .wr_ready (wr_ready),
    .we       (we),
    .waddr    (waddr),
    .wgray    (wgray)
  );

  xfifo_mem #(.DW(DW), .AW(AW)) u_mem (
    .wclk  (wclk),
    .we    (we),
    .waddr (waddr),
    .wdata (wr_data),
    .raddr (raddr),
    .rdata (mem_rdata)
  );

  xfifo_sync #(.W(AW+1), .STAGES(STAGES)) u_w2r (
    .clk   (rclk),
    .rst_n (mrst_n),
    .d     (wgray),
    .q     (wgray_s)
  );

  xfifo_sync #(.W(AW+1), .STAGES(STAGES)) u_r2w (
    .clk   (wclk),
    .rst_n (mrst_n),
    .d     (rgray),
    .q     (rgray_s)
  );

  xfifo_rctl #(.DW(DW), .AW(AW)) u_rctl (
    .rclk      (rclk),
    .mrst_n    (mrst_n),
    .fwft_sel  (fwft_sel),
    .rd_en     (rd_en),
    .wgray_s   (wgray_s),
    .mem_rdata (mem_rdata),
    .raddr     (raddr),
    .rgray     (rgray),
    .rd_data   (rd_data),
    .rd_valid  (rd_valid)
  );

endmodule

// File: tb/xfifo_dc_tb.sv
`timescale 1ns/100ps
module xfifo_dc_tb;

  localparam int DW    = 16;
  localparam int DEPTH = 16;

  logic          wclk = 1'b0;
  logic          rclk = 1'b0;
  logic          mrst_n = 1'b0;
  logic          fwft_sel = 1'b0;
  logic          wr_en = 1'b0;
  logic [DW-1:0] wr_data = '0;
  logic          wr_ready;
  logic          rd_en = 1'b0;
  logic [DW-1:0] rd_data;
  logic          rd_valid;

  int n_chk  = 0;
  int n_fail = 0;
  logic [DW-1:0] refq [$];

  xfifo_dc #(.DW(DW), .DEPTH(DEPTH)) u_dut (
    .wclk     (wclk),
    .rclk     (rclk),
    .mrst_n   (mrst_n),
    .fwft_sel (fwft_sel),
    .wr_en    (wr_en),
    .wr_data  (wr_data),
    .wr_ready (wr_ready),
    .rd_en    (rd_en),
    .rd_data  (rd_data),
    .rd_valid (rd_valid)
  );

  always #2 wclk = ~wclk;
  initial begin
    #0.9;
    forever #3.5 rclk = ~rclk;
  end

  task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr_cycle(input logic [DW-1:0] d, output logic took);
    @(negedge wclk);
    wr_en   = 1'b1;
    wr_data = d;
    took    = wr_ready;
    @(posedge wclk);
    #0.2 wr_en = 1'b0;
  endtask

  task automatic rd_cycle(input logic en, output logic took, output logic [DW-1:0] pre, output logic [DW-1:0] post);
    @(negedge rclk);
    rd_en = en;
    took  = en && rd_valid;
    pre   = rd_data;
    @(posedge rclk);
    #0.2 rd_en = 1'b0;
    post  = rd_data;
  endtask

  task automatic rwait(input int n);
    for (int i = 0; i < n; i++) @(posedge rclk);
    #0.2;
  endtask

  task automatic do_reset(input logic mode);
    mrst_n   = 1'b0;
    fwft_sel = mode;
    wr_en    = 1'b0;
    rd_en    = 1'b0;
    refq.delete();
    rwait(4);
    mrst_n = 1'b1;
    rwait(3);
    // R11
    chk(wr_ready == 1'b1, "R11 wr_ready", 32'(wr_ready), 1);
    chk(rd_valid == 1'b0, "R11 rd_valid", 32'(rd_valid), 0);
    chk(rd_data == '0, "R11 rd_data", 32'(rd_data), 0);
  endtask

  // drain everything in the reference queue, checking order
  task automatic drain(input logic mode, input string req);
    logic took;
    logic [DW-1:0] pre, post, got;
    int guard = 0;
    while (refq.size() > 0 && guard < 20 * DEPTH) begin
      rd_cycle(1'b1, took, pre, post);
      guard++;
      if (took) begin
        got = mode ? pre : post;
        chk(got == refq[0], req, 32'(got), 32'(refq[0]));
        void'(refq.pop_front());
      end
    end
    chk(refq.size() == 0, {req, " drained"}, 32'(refq.size()), 0);
  endtask

  task automatic fill(input logic [DW-1:0] base, output int acc);
    logic took;
    acc = 0;
    for (int i = 0; i < 2 * DEPTH + 4; i++) begin
      wr_cycle(base + DW'(i), took);
      if (took) begin
        acc++;
        refq.push_back(base + DW'(i));
      end else begin
        repeat (3) @(posedge wclk);
      end
    end
  endtask

  // R1 R3 R8 standard fill and release
  task automatic t_std_fill();
    int acc;
    logic took;
    logic [DW-1:0] pre, post;
    do_reset(1'b0);
    fill(16'h1000, acc);
    chk(acc == DEPTH, "R1 capacity", 32'(acc), DEPTH);
    chk(wr_ready == 1'b0, "R1 full", 32'(wr_ready), 0);
    rd_cycle(1'b1, took, pre, post);
    chk(post == refq[0], "R4 first read", 32'(post), 32'(refq[0]));
    void'(refq.pop_front());
    @(posedge wclk); #0.2;
    chk(wr_ready == 1'b0, "R8 wr_ready after 1 wclk", 32'(wr_ready), 0);
    @(posedge wclk); #0.2;
    chk(wr_ready == 1'b1, "R8 wr_ready after 2 wclk", 32'(wr_ready), 1);
    drain(1'b0, "R3 order after dropped writes");
    rwait(4);
    chk(rd_valid == 1'b0, "R3 no extra word", 32'(rd_valid), 0);
  endtask

  // R8 R4 R5 standard single word
  task automatic t_std_single();
    logic took;
    logic [DW-1:0] pre, post;
    do_reset(1'b0);
    wr_cycle(16'h5A5A, took);
    @(posedge rclk); #0.2;
    chk(rd_valid == 1'b0, "R8 rd_valid after 1 rclk", 32'(rd_valid), 0);
    @(posedge rclk); #0.2;
    chk(rd_valid == 1'b1, "R8 rd_valid after 2 rclk", 32'(rd_valid), 1);
    chk(rd_data == '0, "R4 no load without read", 32'(rd_data), 0);
    rd_cycle(1'b1, took, pre, post);
    chk(post == 16'h5A5A, "R4 read data", 32'(post), 32'h5A5A);
    rwait(1);
    chk(rd_valid == 1'b0, "R5 empty after read", 32'(rd_valid), 0);
    rd_cycle(1'b1, took, pre, post);
    chk(post == 16'h5A5A, "R5 empty read ignored", 32'(post), 32'h5A5A);
    wr_cycle(16'h0707, took);
    rwait(4);
    rd_cycle(1'b1, took, pre, post);
    chk(post == 16'h0707, "R5 next word after empty read", 32'(post), 32'h0707);
  endtask

  // R6 R7 fall-through latency and last word
  task automatic t_fwft_single();
    logic took;
    logic [DW-1:0] pre, post;
    do_reset(1'b1);
    wr_cycle(16'hC0DE, took);
    @(posedge rclk); #0.2;
    chk(rd_valid == 1'b0, "R6 edge 1", 32'(rd_valid), 0);
    @(posedge rclk); #0.2;
    chk(rd_valid == 1'b0, "R6 edge 2", 32'(rd_valid), 0);
    @(posedge rclk); #0.2;
    chk(rd_valid == 1'b1, "R6 edge 3 valid", 32'(rd_valid), 1);
    chk(rd_data == 16'hC0DE, "R6 edge 3 data", 32'(rd_data), 32'hC0DE);
    rwait(5);
    chk(rd_valid == 1'b1, "R7 held valid", 32'(rd_valid), 1);
    chk(rd_data == 16'hC0DE, "R7 held data", 32'(rd_data), 32'hC0DE);
    rd_cycle(1'b1, took, pre, post);
    chk(took && pre == 16'hC0DE, "R7 consumed word", 32'(pre), 32'hC0DE);
    chk(rd_valid == 1'b0, "R7 valid falls on read", 32'(rd_valid), 0);
    chk(post == 16'hC0DE, "R7 last word stays", 32'(post), 32'hC0DE);
  endtask

  // R2 fall-through capacity
  task automatic t_fwft_fill();
    int acc;
    logic took;
    do_reset(1'b1);
    wr_cycle(16'h2000, took);
    refq.push_back(16'h2000);
    rwait(6);
    fill(16'h2001, acc);
    chk(acc + 1 == DEPTH + 1, "R2 capacity", 32'(acc + 1), DEPTH + 1);
    chk(wr_ready == 1'b0, "R2 full", 32'(wr_ready), 0);
    drain(1'b1, "R2 order");
  endtask

  // R10 mode change after reset ignored
  task automatic t_mode_latch();
    logic took;
    logic [DW-1:0] pre, post;
    do_reset(1'b0);
    fwft_sel = 1'b1;
    wr_cycle(16'hBEEF, took);
    rwait(6);
    chk(rd_valid == 1'b1, "R10 standard valid", 32'(rd_valid), 1);
    chk(rd_data == '0, "R10 no fall-through", 32'(rd_data), 0);
    rd_cycle(1'b1, took, pre, post);
    chk(post == 16'hBEEF, "R10 requested read", 32'(post), 32'hBEEF);
    fwft_sel = 1'b0;
  endtask

  // R9 concurrent traffic with wrap-around
  task automatic t_stream(input logic mode);
    int n = 4 * DEPTH + 3;
    do_reset(mode);
    fork
      begin
        logic [7:0] lf = 8'h5B;
        logic took;
        int sent = 0;
        while (sent < n) begin
          lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
          if (lf[0] | lf[2]) begin
            wr_cycle(16'h3000 + DW'(sent), took);
            if (took) begin
              refq.push_back(16'h3000 + DW'(sent));
              sent++;
            end
          end else begin
            @(posedge wclk);
          end
        end
      end
      begin
        logic [7:0] lf = 8'hA7;
        logic took;
        logic [DW-1:0] pre, post, got;
        int seen = 0;
        while (seen < n) begin
          lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
          rd_cycle(lf[1] | lf[3], took, pre, post);
          if (took) begin
            got = mode ? pre : post;
            chk(refq.size() > 0 && got == refq[0], mode ? "R9 fwft order" : "R9 std order",
                32'(got), refq.size() > 0 ? 32'(refq[0]) : 32'hFFFF_FFFF);
            if (refq.size() > 0) void'(refq.pop_front());
            seen++;
          end
        end
      end
    join
  endtask

  initial begin
    #100000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    t_std_single();
    t_std_fill();
    t_fwft_single();
    t_fwft_fill();
    t_mode_latch();
    t_stream(1'b0);
    t_stream(1'b1);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule